// File: doc/BRIEF.md
# Split-Section Decade Ripple Counter

This block is a four-bit counter built from two sections with separate clock inputs. The low section is a single toggle bit that divides its clock by two. The high section is a three-bit modulo-five stage that drives the upper three output bits. Each section advances only on a falling edge of its own clock. A parent block can use either section alone as a divide-by-2 or divide-by-5 divider. When output bit 0 is routed back into the high-section clock, the four outputs form a BCD digit that counts from 0 to 9 and wraps, which divides the low-section clock by ten.

Two gated control groups override counting without waiting for a clock. When every line of the clear group is high, all outputs are driven to zero. When every line of the preset group is high, the outputs are driven to nine, and this takes priority over the clear group. The forced value holds for as long as the group stays fully asserted. After release, counting resumes from the forced value at the next falling clock edge. The number of lines in each group is a parameter.

Top module: `dcnt_split_decade`

## Requirements
- R1: Neither section changes state on a rising edge of its clock. Both sections advance only on a falling edge.
- R2: Output bit q[0] inverts on every falling edge of clk_a and ignores clk_b. Used alone, it divides clk_a by two.
- R3: The field q[3:1] steps 0,1,2,3,4,0 (binary, q[1] least significant) on each falling edge of clk_b and ignores clk_a. An unused field value (5, 6 or 7) returns to 0 on the next falling edge of clk_b.
- R4: With clk_b driven by q[0], q reads as an unsigned binary value that follows 0,1,...,9,0 on successive falling edges of clk_a.
- R5: When every bit of clr_req is high and set_req is not all high, q becomes 0 at once, without any clock edge.
- R6: When every bit of set_req is high, q becomes 9 (q[3] and q[0] high, q[2] and q[1] low) at once, whatever clr_req holds.
- R7: A group with only some of its bits high has no effect, and counting continues normally.
- R8: While a group is fully asserted, clock edges do not change q. After release, the next falling edge advances q from the forced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of the toggle section. Acts on falling edges. |
| clk_b | input | 1 | Clock of the modulo-five section. Acts on falling edges. Tie to q[0] for decade counting. |
| clr_req | input | GATE_N | Clear group. Forces q to zero when all bits are high. |
| set_req | input | GATE_N | Preset group. Forces q to nine when all bits are high. Wins over the clear group. |
| q | output | 4 | Count value. q[0] comes from the toggle section and q[3:1] from the modulo-five section. |

## Verification
Both sections drive the outputs directly from their state registers, so a wrong state in either section shows on q from the same instant, with no decoding delay. A toggle bit that fails to invert shows as a repeated parity. In decade mode it also stalls the high field, because that field is clocked by q[0]'s falling edge. A modulo-five field that skips a value or wraps late shows within one falling edge of clk_b as a field value outside 0 to 4 or a wrong step. The bench sweeps every start value of the decade against every combination of the two control groups.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/1ps
package dcnt_pkg;

  // Section widths and the modulus of the high section.
  localparam int LO_W    = 1;
  localparam int HI_W    = 3;
  localparam int Q_W     = LO_W + HI_W;
  localparam int HI_MOD  = 5;
  localparam int HI_LAST = HI_MOD - 1;

  // Forced value for the preset group, split per section.
  localparam logic [Q_W-1:0]  NINE_CODE = Q_W'(9);
  localparam logic [LO_W-1:0] NINE_LO   = NINE_CODE[LO_W-1:0];
  localparam logic [HI_W-1:0] NINE_HI   = NINE_CODE[Q_W-1:LO_W];

  typedef enum logic [1:0] {
    FM_RUN  = 2'd0,
    FM_ZERO = 2'd1,
    FM_NINE = 2'd2
  } force_mode_e;

  // Preset beats clear; neither fully asserted means run.
  function automatic force_mode_e pick_mode(input logic clr_all, input logic set_all);
    if (set_all)      return FM_NINE;
    else if (clr_all) return FM_ZERO;
    else              return FM_RUN;
  endfunction

  // Next value of the modulo-five field; any value at or past the last
  // legal one (including unused codes) goes back to zero.
  function automatic logic [HI_W-1:0] hi_step(input logic [HI_W-1:0] s);
    return (s >= HI_W'(HI_LAST)) ? '0 : s + HI_W'(1);
  endfunction

  function automatic logic hi_legal(input logic [HI_W-1:0] s);
    return s < HI_W'(HI_MOD);
  endfunction

endpackage

// File: rtl/dcnt_force_decode.sv
`timescale 1ns/1ps
module dcnt_force_decode
  import dcnt_pkg::*;
#(
  parameter int GATE_N = 2
) (
  input  logic [GATE_N-1:0] clr_req,
  input  logic [GATE_N-1:0] set_req,
  output logic              to_zero,
  output logic              to_nine
);

  force_mode_e mode;
  logic        clr_all;
  logic        set_all;

  always_comb begin
    clr_all = &clr_req;
    set_all = &set_req;
    mode    = pick_mode(clr_all, set_all);
    to_zero = (mode == FM_ZERO);
    to_nine = (mode == FM_NINE);

    // R6: a full preset group always yields the nine force, never clear
    if (&set_req) begin
      p_nine_wins_r6: assert (to_nine && !to_zero);
    end
    // R7: a partial group never raises a force line
    if (!(&set_req) && !(&clr_req)) begin
      p_partial_idle_r7: assert (!to_nine && !to_zero);
    end
  end

endmodule

// File: rtl/dcnt_half_stage.sv
`timescale 1ns/1ps
module dcnt_half_stage
  import dcnt_pkg::*;
(
  input  logic clk_n,
  input  logic to_zero,
  input  logic to_nine,
  output logic bit_q
);

  always_ff @(negedge clk_n or posedge to_zero or posedge to_nine) begin
    if (to_nine)      bit_q <= NINE_LO[0];
    else if (to_zero) bit_q <= 1'b0;
    else              bit_q <= ~bit_q;
  end

  // R6: while preset is held the bit sits at its nine value
  p_lo_nine_r6: assert property (@(negedge clk_n) disable iff (to_zero)
    to_nine |-> (bit_q == NINE_LO[0]));

  // R5: while clear alone is held the bit sits at zero
  p_lo_zero_r5: assert property (@(negedge clk_n) disable iff (to_nine)
    to_zero |-> (bit_q == 1'b0));

endmodule

// File: rtl/dcnt_quint_stage.sv
`timescale 1ns/1ps
module dcnt_quint_stage
  import dcnt_pkg::*;
(
  input  logic            clk_n,
  input  logic            to_zero,
  input  logic            to_nine,
  output logic [HI_W-1:0] st
);

  always_ff @(negedge clk_n or posedge to_zero or posedge to_nine) begin
    if (to_nine)      st <= NINE_HI;
    else if (to_zero) st <= '0;
    else              st <= hi_step(st);
  end

  // R6: preset holds the field at the upper part of nine
  p_hi_nine_r6: assert property (@(negedge clk_n) disable iff (to_zero)
    to_nine |-> (st == NINE_HI));

  // R5: clear alone holds the field at zero
  p_hi_zero_r5: assert property (@(negedge clk_n) disable iff (to_nine)
    to_zero |-> (st == '0));

  // R3: after any falling edge the field is inside the count cycle
  p_hi_legal_r3: assert property (@(negedge clk_n) disable iff (to_nine)
    1'b1 |=> hi_legal(st));

endmodule

// File: rtl/dcnt_split_decade.sv
`timescale 1ns/1ps
module dcnt_split_decade
  import dcnt_pkg::*;
#(
  parameter int GATE_N = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic [GATE_N-1:0] clr_req,
  input  logic [GATE_N-1:0] set_req,
  output logic [Q_W-1:0]    q
);

  // Internal events brought out as named wires.
  logic            to_zero;
  logic            to_nine;
  logic            lo_bit;
  logic [HI_W-1:0] hi_st;

  dcnt_force_decode #(.GATE_N(GATE_N)) u_decode (
    .clr_req (clr_req),
    .set_req (set_req),
    .to_zero (to_zero),
    .to_nine (to_nine)
  );

  dcnt_half_stage u_half (
    .clk_n   (clk_a),
    .to_zero (to_zero),
    .to_nine (to_nine),
    .bit_q   (lo_bit)
  );

  dcnt_quint_stage u_quint (
    .clk_n   (clk_b),
    .to_zero (to_zero),
    .to_nine (to_nine),
    .st      (hi_st)
  );

  assign q = {hi_st, lo_bit};

  // R4: the combined value never leaves the BCD range 0..9
  p_bcd_range_r4: assert property (@(negedge clk_a) disable iff (to_nine)
    1'b1 |=> (q <= Q_W'(9)));

endmodule

// File: tb/dcnt_split_decade_test.sv
`timescale 1ns/1ps
module dcnt_split_decade_test;

  logic       clk   = 1'b0;
  logic       a_drv = 1'b0;
  logic       b_drv = 1'b0;
  logic       chain = 1'b0;
  logic [1:0] clr_req = 2'b11;
  logic [1:0] set_req = 2'b00;
  wire  [3:0] q;
  wire        clk_b = chain ? q[0] : b_drv;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dcnt_split_decade #(.GATE_N(2)) uut (
    .clk_a   (a_drv),
    .clk_b   (clk_b),
    .clr_req (clr_req),
    .set_req (set_req),
    .q       (q)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic pulse_a();
    @(posedge clk); #1 a_drv = 1'b1;
    @(posedge clk); #1 a_drv = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_b();
    @(posedge clk); #1 b_drv = 1'b1;
    @(posedge clk); #1 b_drv = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_ctl(input logic [1:0] c, input logic [1:0] s);
    @(posedge clk); #1 clr_req = c; set_req = s;
    @(negedge clk);
  endtask

  // Switch routing only while clear holds, so a routing edge cannot count.
  task automatic enter_mode(input logic ch);
    drive_ctl(2'b11, 2'b00);
    @(posedge clk); #1 chain = ch; b_drv = 1'b0;
    @(negedge clk);
    drive_ctl(2'b00, 2'b00);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    string tag;
    int    e;
    int    nxt;

    // Reset state under clear (R5)
    repeat (2) @(negedge clk);
    check("R5 reset", q, 0);
    drive_ctl(2'b00, 2'b00);
    check("R5 after release", q, 0);

    // Decade routing: 0..9 and wrap (R4)
    enter_mode(1'b1);
    for (int i = 1; i <= 25; i++) begin
      pulse_a();
      check("R4 decade", q, i % 10);
    end

    // Rising edge of clk_a has no effect (R1)
    @(posedge clk); #1 a_drv = 1'b1;
    @(negedge clk);
    check("R1 rising clk_a", q, 5);
    @(posedge clk); #1 a_drv = 1'b0;
    @(negedge clk);
    check("R1 falling clk_a", q, 6);

    // Toggle section alone (R2)
    enter_mode(1'b0);
    for (int i = 1; i <= 6; i++) begin
      pulse_a();
      check("R2 divide by two", q, i % 2);
    end

    // Modulo-five section alone, low bit parked high (R3)
    enter_mode(1'b0);
    pulse_a();
    for (int i = 1; i <= 12; i++) begin
      pulse_b();
      check("R3 divide by five", q, ((i % 5) << 1) | 1);
    end

    // Rising edge of clk_b has no effect (R1)
    @(posedge clk); #1 b_drv = 1'b1;
    @(negedge clk);
    check("R1 rising clk_b", q, 5);
    @(posedge clk); #1 b_drv = 1'b0;
    @(negedge clk);
    check("R1 falling clk_b", q, 7);

    // Every start value against every control combination (R5..R8)
    enter_mode(1'b1);
    for (int v = 0; v < 10; v++) begin
      for (int c = 0; c < 16; c++) begin
        drive_ctl(2'b11, 2'b00);
        drive_ctl(2'b00, 2'b00);
        for (int k = 0; k < v; k++) pulse_a();
        drive_ctl(c[1:0], c[3:2]);
        if (c[3:2] == 2'b11) begin
          tag = "R6 preset";
          e = 9;
        end else if (c[1:0] == 2'b11) begin
          tag = "R5 clear";
          e = 0;
        end else begin
          tag = "R7 partial";
          e = v;
        end
        check(tag, q, e);
        pulse_a();
        nxt = (e == v && tag == "R7 partial") ? (v + 1) % 10 : e;
        check("R8 edge while forced", q, nxt);
        drive_ctl(2'b00, 2'b00);
        check("R8 release holds", q, nxt);
        pulse_a();
        check("R8 resume", q, (nxt + 1) % 10);
      end
    end

    summary();
    $finish;
  end

endmodule